// File: doc/BRIEF.md
# SCL Bit-Rate Prescaler

This block derives the timing strobes for an I2C engine from the peripheral bus clock. A power-of-two first stage turns the bus clock into a sample-rate strobe. A second stage divides that strobe by M+1 to produce a phase strobe. Ten phase strobes make one SCL period, so the bus rate is Fin / (2^N × (M+1) × 10). A duty select picks how many of the ten phase slots the SCL request is held high.

The engine sets the exponent, divisor and duty select, then raises `enable`. While the block is disabled, its active settings follow the inputs on every cycle. While it runs, it reloads them only at the end of an SCL period, so a period never comes out shortened or mixed. Dropping `enable` clears every counter and returns the SCL request high at once.

Top module: `scl_prescaler`

## Requirements
- R1: While `enable` is low, `sample_tick` and `phase_tick` stay low and `scl_high` is 1. On the next rise of `enable`, a full SCL period starts with SCL high.
- R2: With active exponent N (3-bit `cfg_exp`), `sample_tick` pulses once every 2^N clock cycles. The first pulse falls in the 2^N-th enabled cycle.
- R3: With active divisor M (4-bit `cfg_div`), `phase_tick` pulses on every (M+1)-th `sample_tick`, and only in a cycle where `sample_tick` is also high.
- R4: One SCL period spans 10 phase strobes, which is 2^N × (M+1) × 10 clock cycles.
- R5: With `cfg_duty` = 0, SCL is high for 5 phase slots and then low for 5. With `cfg_duty` = 1, it is high for 4 slots and then low for 6. Each period starts high.
- R6: A change to `cfg_exp`, `cfg_div` or `cfg_duty` while enabled leaves the current period at its old lengths. The new setting takes effect from the next period.
- R7: The reset value N=0, M=0 is the fastest rate: both strobes fire every cycle and the SCL period is 10 cycles.
- R8: While enabled, `scl_high` changes only in the cycle after a `phase_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator. Low clears all counters |
| cfg_exp | input | 3 | First-stage exponent N (divide by 2^N) |
| cfg_div | input | 4 | Second-stage divisor M (divide by M+1) |
| cfg_duty | input | 1 | 0: 5 high / 5 low slots; 1: 4 high / 6 low slots |
| sample_tick | output | 1 | Sample-rate strobe, one cycle wide |
| phase_tick | output | 1 | Phase strobe, one cycle wide |
| scl_high | output | 1 | Requested SCL level (1 = release high) |

## Verification
The settings reload and the last phase strobe of a period share a single cycle. A setting change that arrives mid-period must therefore wait for that cycle and must not alter the period already in flight. The bench provokes this by changing all three settings just after a period has begun. Its scoreboard then expects one more period at the old high and low lengths, followed by periods at the new lengths. The bench also checks that `sample_tick` and `phase_tick` coincide on every phase strobe. It does this by counting both strobes over a measured window after each enable.

// File: rtl/scl_prescaler_pkg.sv
package scl_prescaler_pkg;

  // Number of input cycles covered by one first-stage strobe.
  function automatic int unsigned pow2_span(input int unsigned expo);
    return 32'd1 << expo;
  endfunction

  // Number of high phase slots in one SCL period.
  function automatic int unsigned scl_high_slots(input logic skew,
                                                 input int unsigned even_slots,
                                                 input int unsigned skew_slots);
    return skew ? skew_slots : even_slots;
  endfunction

endpackage

// File: rtl/pow2_stage.sv
module pow2_stage #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  import scl_prescaler_pkg::*;

  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'(pow2_span(32'(expo)) - 32'd1);
  end

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/modm_stage.sv
module modm_stage #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = step && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (step)   cnt <= tick ? '0 : cnt + DIV_W'(1);
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int PERIOD_TICKS = 10,
  parameter int HIGH_EVEN    = 5,
  parameter int HIGH_SKEW    = 4,
  parameter bit DUTY_SEL_EN  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  input  logic duty,
  output logic scl_high,
  output logic boundary
);
  import scl_prescaler_pkg::*;

  localparam int PH_W = $clog2(PERIOD_TICKS);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] high_slots;

  generate
    if (DUTY_SEL_EN) begin : g_duty_sel
      always_comb high_slots = PH_W'(scl_high_slots(duty, HIGH_EVEN, HIGH_SKEW));
    end else begin : g_duty_fixed
      logic unused_duty;
      assign unused_duty = duty;
      always_comb high_slots = PH_W'(HIGH_EVEN);
    end
  endgenerate

  assign boundary = step && (ph == PH_W'(PERIOD_TICKS - 1));
  assign scl_high = !run || (ph < high_slots);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph <= '0;
    else if (!run)   ph <= '0;
    else if (step)   ph <= boundary ? '0 : ph + PH_W'(1);
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int EXP_W        = 3,
  parameter int DIV_W        = 4,
  parameter int PERIOD_TICKS = 10,
  parameter int HIGH_EVEN    = 5,
  parameter int HIGH_SKEW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [EXP_W-1:0] cfg_exp,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_duty,
  output logic             sample_tick,
  output logic             phase_tick,
  output logic             scl_high
);
  localparam int CFG_W = EXP_W + DIV_W + 1;

  // Active settings: {duty, div, exp}
  logic [CFG_W-1:0] act_cfg;
  logic [EXP_W-1:0] act_exp;
  logic [DIV_W-1:0] act_div;
  logic             act_duty;
  logic             period_boundary;

  assign act_exp  = act_cfg[EXP_W-1:0];
  assign act_div  = act_cfg[EXP_W +: DIV_W];
  assign act_duty = act_cfg[CFG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_cfg <= '0;
    else if (!enable || period_boundary)
      act_cfg <= {cfg_duty, cfg_div, cfg_exp};
  end

  pow2_stage #(.EXP_W(EXP_W)) u_pow2 (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .expo  (act_exp),
    .tick  (sample_tick)
  );

  modm_stage #(.DIV_W(DIV_W)) u_modm (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .step  (sample_tick),
    .div   (act_div),
    .tick  (phase_tick)
  );

  scl_phase_seq #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .HIGH_EVEN    (HIGH_EVEN),
    .HIGH_SKEW    (HIGH_SKEW),
    .DUTY_SEL_EN  (1'b1)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .step     (phase_tick),
    .duty     (act_duty),
    .scl_high (scl_high),
    .boundary (period_boundary)
  );
endmodule

// File: rtl/scl_prescaler_chk.sv
module scl_prescaler_chk #(
  parameter int EXP_W        = 3,
  parameter int CFG_W        = 8,
  parameter int PERIOD_TICKS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             sample_tick,
  input logic             phase_tick,
  input logic             scl_high,
  input logic [EXP_W-1:0] act_exp,
  input logic [CFG_W-1:0] act_cfg,
  input logic             period_boundary
);
  localparam int GAP_W = (1 << EXP_W) + 1;
  localparam int PC_W  = $clog2(PERIOD_TICKS) + 1;

  logic [GAP_W-1:0] gap;
  logic [PC_W-1:0]  phase_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap <= '0;
    else if (!enable)       gap <= '0;
    else if (sample_tick)   gap <= '0;
    else                    gap <= gap + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase_cnt <= '0;
    else if (!enable)       phase_cnt <= '0;
    else if (phase_tick)    phase_cnt <= period_boundary ? '0 : phase_cnt + PC_W'(1);
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!sample_tick && !phase_tick && scl_high)); // R1

  AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> ((gap + GAP_W'(1)) == (GAP_W'(1) << act_exp))); // R2

  AST_PHASE_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> sample_tick); // R3

  AST_TEN_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    period_boundary |-> (phase_cnt == PC_W'(PERIOD_TICKS - 1))); // R4

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(period_boundary)) |-> $stable(act_cfg)); // R6

  AST_SCL_MOVES_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (scl_high != $past(scl_high))) |-> $past(phase_tick)); // R8
endmodule

bind scl_prescaler scl_prescaler_chk #(
  .EXP_W        (EXP_W),
  .CFG_W        (CFG_W),
  .PERIOD_TICKS (PERIOD_TICKS)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .enable          (enable),
  .sample_tick     (sample_tick),
  .phase_tick      (phase_tick),
  .scl_high        (scl_high),
  .act_exp         (act_exp),
  .act_cfg         (act_cfg),
  .period_boundary (period_boundary)
);

// File: tb/tb_scl_prescaler.sv
`timescale 1ns/1ps
module tb_scl_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] cfg_exp = '0;
  logic [3:0] cfg_div = '0;
  logic       cfg_duty = 1'b0;
  logic       sample_tick, phase_tick, scl_high;

  int n_checks = 0;
  int n_err = 0;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } period_t;
  period_t sb[$];

  always #2.5 clk = ~clk;

  scl_prescaler dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_exp(cfg_exp), .cfg_div(cfg_div), .cfg_duty(cfg_duty),
    .sample_tick(sample_tick), .phase_tick(phase_tick), .scl_high(scl_high)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int slot_cycles(input int n, input int m);
    int s = 1;
    for (int i = 0; i < n; i++) s = s * 2;
    return s * (m + 1);
  endfunction

  task automatic push_periods(input int n, input int m, input bit duty,
                              input int count, input string tag);
    int u = slot_cycles(n, m);
    int h = duty ? 4 : 5;
    for (int k = 0; k < count; k++) sb.push_back('{h * u, (10 - h) * u, tag});
  endtask

  task automatic set_cfg(input int n, input int m, input bit duty);
    @(posedge clk); #1;
    cfg_exp = 3'(n); cfg_div = 4'(m); cfg_duty = duty;
  endtask

  task automatic set_enable(input bit v);
    @(posedge clk); #1;
    enable = v;
  endtask

  task automatic wait_empty();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  // Monitor: measures high and low run lengths of each SCL period
  initial begin
    int hi_run = 0;
    int lo_run = 0;
    bit in_low = 1'b0;
    period_t e;
    forever begin
      @(negedge clk);
      if (!rst_n || !enable) begin
        hi_run = 0; lo_run = 0; in_low = 1'b0;
      end else if (scl_high) begin
        if (in_low) begin
          if (sb.size() == 0) begin
            check(1'b0, "R4 unexpected period", hi_run, 0);
          end else begin
            e = sb.pop_front();
            check(hi_run == e.hi, {e.tag, " high cycles"}, hi_run, e.hi);
            check(lo_run == e.lo, {e.tag, " low cycles"}, lo_run, e.lo);
          end
          hi_run = 1; lo_run = 0; in_low = 1'b0;
        end else begin
          hi_run++;
        end
      end else begin
        in_low = 1'b1;
        lo_run++;
      end
    end
  end

  // Strobe counting over exactly one SCL period after enable
  task automatic check_ticks(input int n, input int m, input string tag);
    int u = slot_cycles(n, m);
    int first = 0;
    int samples = 0;
    int phases = 0;
    int lone = 0;
    set_cfg(n, m, 1'b0);
    set_enable(1'b1);
    for (int i = 1; i <= 10 * u; i++) begin
      @(negedge clk);
      if (sample_tick) begin
        samples++;
        if (first == 0) first = i;
      end
      if (phase_tick) begin
        phases++;
        if (!sample_tick) lone++;
      end
    end
    set_enable(1'b0);
    check(first == slot_cycles(n, 0), {tag, " R2 first sample cycle"}, first, slot_cycles(n, 0));
    check(samples == 10 * (m + 1), {tag, " R2 sample count"}, samples, 10 * (m + 1));
    check(phases == 10, {tag, " R3 phase count"}, phases, 10);
    check(lone == 0, {tag, " R3 phase without sample"}, lone, 0);
  endtask

  task automatic run_periods(input int n, input int m, input bit duty,
                             input int count, input string tag);
    set_cfg(n, m, duty);
    set_enable(1'b1);
    push_periods(n, m, duty, count, tag);
    wait_empty();
    set_enable(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl_high == 1'b1, "R1 reset scl_high", int'(scl_high), 1);
    check(sample_tick == 1'b0 && phase_tick == 1'b0, "R1 reset strobes",
          int'(sample_tick) + int'(phase_tick), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Strobe rates
    check_ticks(0, 0, "R7");
    check_ticks(2, 3, "R3");
    check_ticks(1, 0, "R2");

    // Period and duty measurements
    run_periods(0, 0, 1'b0, 3, "R7");
    run_periods(0, 0, 1'b1, 2, "R5");
    run_periods(1, 2, 1'b0, 2, "R4");
    run_periods(2, 1, 1'b1, 2, "R5");
    run_periods(3, 0, 1'b0, 1, "R4");

    // Mid-period change: old period completes, new setting next
    set_cfg(1, 1, 1'b0);
    set_enable(1'b1);
    push_periods(1, 1, 1'b0, 2, "R6 old");
    wait_empty();
    set_cfg(0, 2, 1'b1);
    push_periods(1, 1, 1'b0, 1, "R6 in-flight");
    push_periods(0, 2, 1'b1, 2, "R6 new");
    wait_empty();
    set_enable(1'b0);

    // Disable in the low phase, then restart with a full period
    set_cfg(1, 0, 1'b0);
    set_enable(1'b1);
    repeat (14) @(negedge clk);
    check(scl_high == 1'b0, "R5 low phase reached", int'(scl_high), 0);
    set_enable(1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(scl_high == 1'b1 && !sample_tick && !phase_tick, "R1 disabled idle",
            int'(scl_high), 1);
    end
    set_enable(1'b1);
    push_periods(1, 0, 1'b0, 1, "R1 restart");
    wait_empty();
    set_enable(1'b0);
    repeat (3) @(negedge clk);

    check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
    report();
  end
endmodule